// File: doc/BRIEF.md
# Time-Slot Shared Memory Arbiter

This block decides, slot by slot, which requester drives a shared 16-bit memory bus. The slot clock runs at twice the processor clock, and every slot carries one transfer. Even slots are processor phases. Odd slots fall in the processor's internal phase, and fixed-rate channels (audio, disk, sprites and similar) hold preassigned odd slots there. The display fetch unit claims a pattern of slots that grows with the plane count. Two cycle-stealing requesters take what remains: a display-list coprocessor and a block-transfer engine. The block-transfer engine can be set to step aside whenever the processor asks for its slot.

A free-running slot counter defines the line. It wraps at a parameterised line length and is forced back to zero by a line-start pulse. The grant vector and the processor wait flag are combinational functions of the registered slot index and the request inputs, so the grant for a slot appears in the same cycle as its index. Processor accesses decoded as external memory never touch the shared bus and never wait. The processor keeps its shared-memory request asserted until it is granted.

Top module: `tslot_arbiter`

## Requirements
- R1: After reset `slot_idx` is 0. It advances by one each clock and returns to 0 after `LINE_SLOTS-1`.
- R2: A `line_start` pulse makes `slot_idx` 0 in the next cycle, overriding the normal advance.
- R3: At most one bit of `gnt` is set in any cycle, and a bit is set only for a requester whose request input is high. Bit order: bits 0..NUM_FIX-1 are the fixed channels, then display at NUM_FIX, coprocessor at NUM_FIX+1, processor at NUM_FIX+2, block engine at NUM_FIX+3.
- R4: Fixed channel k owns every odd slot s with (s/2) mod FIX_STRIDE equal to k (k < NUM_FIX). It is granted there whenever it requests, whatever any other input does, and is never granted in any other slot.
- R5: The processor is granted only in even slots. Fixed channels never take an even slot, so their activity never stalls the processor.
- R6: With plane count n (values above 4 act as 4), display fetch claims slot positions p = s mod 8 as follows: 1 and 5 when n>=1; 3 and 7 when n>=2; 0 and 4 when n>=3; 2 and 6 when n=4. It wins a claimed slot when it requests and the owning fixed channel is not requesting. As a result, n<=2 never blocks an even slot.
- R7: While `hblank` or `vblank` is high, display fetch is never granted.
- R8: The coprocessor wins any slot that is not taken by a fixed channel or display fetch, ahead of the processor and the block engine.
- R9: In a slot left free by the higher requesters: with `blt_yield`=1 a shared-memory processor request in an even slot beats the block engine. With `blt_yield`=0 the block engine beats the processor.
- R10: The block engine may take any remaining slot, odd or even.
- R11: A processor request with `cpu_shared`=0 (external memory) is never granted on the shared bus and never raises `cpu_wait`.
- R12: `cpu_wait` is high exactly when the processor requests shared memory in an even slot and the processor grant bit is low. It is never high in an odd slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twice the processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Restart the slot sequence at 0 |
| fix_req | input | NUM_FIX | Request per fixed-rate channel |
| disp_req | input | 1 | Display fetch request |
| cop_req | input | 1 | Coprocessor request |
| cpu_req | input | 1 | Processor memory request, held until granted |
| cpu_shared | input | 1 | 1 when the processor address decodes to shared memory |
| blt_req | input | 1 | Block-transfer engine request |
| blt_yield | input | 1 | Block engine yields processor slots to the processor |
| hblank | input | 1 | Horizontal blanking |
| vblank | input | 1 | Vertical blanking |
| planes | input | 3 | Display plane count, 0 to 4 |
| gnt | output | NUM_FIX+4 | One-hot grant for the current slot |
| cpu_wait | output | 1 | Processor stalled this slot |
| slot_idx | output | SW | Current slot index |

## Verification
Grants are decoded from the registered slot index in the same cycle. A counter that drifts, skips its wrap or ignores `line_start` therefore shows at once on `slot_idx`, and within a slot or two as fixed-channel grants landing in the wrong odd positions. A fault in the priority chain or the display claim pattern shows in the very cycle it applies, as a wrong `gnt` bit or a wrong `cpu_wait`. The bench sweeps the whole slot pattern of a short line against many request mixes, plane counts and yield settings, and compares every cycle to an arithmetic model.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Offsets of the shared-requester grant bits above the fixed channels.
    typedef enum logic [1:0] {
        SRC_DISP = 2'd0,
        SRC_COP  = 2'd1,
        SRC_CPU  = 2'd2,
        SRC_BLT  = 2'd3
    } shared_src_e;

    localparam int NUM_SHARED = 4;

    // Decoded attributes of the current slot.
    typedef struct packed {
        logic       cpu_phase;   // even slot: processor may use it
        logic       owned;       // odd slot preassigned to a fixed channel
        logic [7:0] owner;       // which fixed channel owns it
        logic       disp_claim;  // display fetch claims it at this plane count
    } slot_class_t;

endpackage

// File: rtl/arb_slot_counter.sv
module arb_slot_counter #(
    parameter int LINE_SLOTS = 228,
    parameter int SW         = (LINE_SLOTS > 1) ? $clog2(LINE_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    output logic [SW-1:0] slot_o
);

    localparam logic [SW-1:0] LAST = SW'(LINE_SLOTS - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d.slot = '0;
        end else if (st_q.slot == LAST) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;

endmodule

// File: rtl/arb_slot_map.sv
module arb_slot_map
    import arb_pkg::*;
#(
    parameter int SW         = 8,
    parameter int NUM_FIX    = 4,
    parameter int FIX_STRIDE = 8
) (
    input  logic [SW-1:0] slot_i,
    input  logic [2:0]    planes_i,
    output slot_class_t   cls_o
);

    int unsigned pair_i;
    int unsigned pos_i;
    logic [2:0]  n_eff;
    logic [2:0]  need;

    always_comb begin
        // Fixed ownership: odd slots, channel picked by pair index modulo stride.
        pair_i = 32'(slot_i >> 1);
        pos_i  = pair_i % FIX_STRIDE;
        cls_o.cpu_phase = ~slot_i[0];
        cls_o.owned     = slot_i[0] && (pos_i < NUM_FIX);
        cls_o.owner     = 8'(pos_i);

        // Display claim: plane count needed before a position is used.
        n_eff = (planes_i > 3'd4) ? 3'd4 : planes_i;
        unique case (slot_i[1:0])
            2'b01:   need = 3'd1;
            2'b11:   need = 3'd2;
            2'b00:   need = 3'd3;
            default: need = 3'd4;
        endcase
        cls_o.disp_claim = (n_eff >= need);
    end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int NUM_FIX = 4,
    parameter int NG      = NUM_FIX + NUM_SHARED
) (
    input  slot_class_t        cls_i,
    input  logic [NUM_FIX-1:0] fix_req,
    input  logic               disp_req,
    input  logic               cop_req,
    input  logic               cpu_req,
    input  logic               cpu_shared,
    input  logic               blt_req,
    input  logic               blt_yield,
    input  logic               blank,
    output logic [NG-1:0]      gnt,
    output logic               cpu_wait
);

    localparam int B_DISP = NUM_FIX + int'(SRC_DISP);
    localparam int B_COP  = NUM_FIX + int'(SRC_COP);
    localparam int B_CPU  = NUM_FIX + int'(SRC_CPU);
    localparam int B_BLT  = NUM_FIX + int'(SRC_BLT);

    logic [NUM_FIX-1:0] fix_sel;
    logic fix_hit, disp_hit, cop_hit, cpu_ok, free_slot;
    logic cpu_win, blt_win;

    // One selector per fixed channel.
    for (genvar k = 0; k < NUM_FIX; k++) begin : g_fix
        assign fix_sel[k] = cls_i.owned && (cls_i.owner == 8'(k)) && fix_req[k];
    end

    always_comb begin
        fix_hit   = |fix_sel;
        disp_hit  = !fix_hit && cls_i.disp_claim && disp_req && !blank;
        cop_hit   = !fix_hit && !disp_hit && cop_req;
        cpu_ok    = cls_i.cpu_phase && cpu_req && cpu_shared;
        free_slot = !(fix_hit || disp_hit || cop_hit);

        cpu_win = 1'b0;
        blt_win = 1'b0;
        if (free_slot) begin
            if (blt_yield) begin
                cpu_win = cpu_ok;
                blt_win = !cpu_ok && blt_req;
            end else begin
                blt_win = blt_req;
                cpu_win = !blt_req && cpu_ok;
            end
        end

        gnt                = '0;
        gnt[NUM_FIX-1:0]   = fix_sel;
        gnt[B_DISP]        = disp_hit;
        gnt[B_COP]         = cop_hit;
        gnt[B_CPU]         = cpu_win;
        gnt[B_BLT]         = blt_win;

        cpu_wait = cpu_ok && !cpu_win;
    end

endmodule

// File: rtl/tslot_arbiter.sv
module tslot_arbiter
    import arb_pkg::*;
#(
    parameter int LINE_SLOTS = 228,
    parameter int NUM_FIX    = 4,
    parameter int FIX_STRIDE = 8,
    parameter int SW         = (LINE_SLOTS > 1) ? $clog2(LINE_SLOTS) : 1,
    parameter int NG         = NUM_FIX + NUM_SHARED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic [NUM_FIX-1:0] fix_req,
    input  logic               disp_req,
    input  logic               cop_req,
    input  logic               cpu_req,
    input  logic               cpu_shared,
    input  logic               blt_req,
    input  logic               blt_yield,
    input  logic               hblank,
    input  logic               vblank,
    input  logic [2:0]         planes,
    output logic [NG-1:0]      gnt,
    output logic               cpu_wait,
    output logic [SW-1:0]      slot_idx
);

    slot_class_t cls;

    arb_slot_counter #(
        .LINE_SLOTS (LINE_SLOTS),
        .SW         (SW)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .slot_o     (slot_idx)
    );

    arb_slot_map #(
        .SW         (SW),
        .NUM_FIX    (NUM_FIX),
        .FIX_STRIDE (FIX_STRIDE)
    ) u_map (
        .slot_i   (slot_idx),
        .planes_i (planes),
        .cls_o    (cls)
    );

    arb_pick #(
        .NUM_FIX (NUM_FIX),
        .NG      (NG)
    ) u_pick (
        .cls_i      (cls),
        .fix_req    (fix_req),
        .disp_req   (disp_req),
        .cop_req    (cop_req),
        .cpu_req    (cpu_req),
        .cpu_shared (cpu_shared),
        .blt_req    (blt_req),
        .blt_yield  (blt_yield),
        .blank      (hblank | vblank),
        .gnt        (gnt),
        .cpu_wait   (cpu_wait)
    );

endmodule

// File: rtl/tslot_arbiter_chk.sv
module tslot_arbiter_chk #(
    parameter int LINE_SLOTS = 228,
    parameter int NUM_FIX    = 4,
    parameter int SW         = 8,
    parameter int NG         = NUM_FIX + 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_start,
    input logic [NUM_FIX-1:0] fix_req,
    input logic               disp_req,
    input logic               cop_req,
    input logic               cpu_req,
    input logic               cpu_shared,
    input logic               blt_req,
    input logic               blt_yield,
    input logic               hblank,
    input logic               vblank,
    input logic [NG-1:0]      gnt,
    input logic               cpu_wait,
    input logic [SW-1:0]      slot_idx
);

    localparam logic [SW-1:0] LAST = SW'(LINE_SLOTS - 1);
    localparam int B_DISP = NUM_FIX;
    localparam int B_CPU  = NUM_FIX + 2;
    localparam int B_BLT  = NUM_FIX + 3;

    logic [NG-1:0] req_vec;
    assign req_vec = {blt_req, cpu_req, cop_req, disp_req, fix_req};

    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && slot_idx != LAST) |=> slot_idx == $past(slot_idx) + 1'b1);

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == LAST) |=> slot_idx == '0);

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> slot_idx == '0);

    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r3_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_vec) == '0);

    a_r5_cpu_even: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[B_CPU] |-> !slot_idx[0]);

    a_r7_blank_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank || vblank) |-> !gnt[B_DISP]);

    a_r9_yield: assert property (@(posedge clk) disable iff (!rst_n)
        (blt_yield && cpu_req && cpu_shared && !slot_idx[0]) |-> !gnt[B_BLT]);

    a_r11_external: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_shared) |-> (!gnt[B_CPU] && !cpu_wait));

    a_r12_wait_even: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx[0] |-> !cpu_wait);

    a_r12_wait_vs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (cpu_req && !gnt[B_CPU]));

endmodule

bind tslot_arbiter tslot_arbiter_chk #(
    .LINE_SLOTS (LINE_SLOTS),
    .NUM_FIX    (NUM_FIX),
    .SW         (SW),
    .NG         (NG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .fix_req    (fix_req),
    .disp_req   (disp_req),
    .cop_req    (cop_req),
    .cpu_req    (cpu_req),
    .cpu_shared (cpu_shared),
    .blt_req    (blt_req),
    .blt_yield  (blt_yield),
    .hblank     (hblank),
    .vblank     (vblank),
    .gnt        (gnt),
    .cpu_wait   (cpu_wait),
    .slot_idx   (slot_idx)
);

// File: tb/tb_tslot_arbiter.sv
module tb_tslot_arbiter;

    localparam int L  = 24;
    localparam int NF = 4;
    localparam int FS = 8;
    localparam int SW = $clog2(L);
    localparam int NG = NF + 4;
    localparam int BD = NF, BC = NF + 1, BP = NF + 2, BB = NF + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic [NF-1:0] fix_req = '0;
    logic disp_req = 1'b0, cop_req = 1'b0, cpu_req = 1'b0, cpu_shared = 1'b0;
    logic blt_req = 1'b0, blt_yield = 1'b0, hblank = 1'b0, vblank = 1'b0;
    logic [2:0] planes = 3'd0;
    logic [NG-1:0] gnt;
    logic cpu_wait;
    logic [SW-1:0] slot_idx;

    int total = 0;
    int bad = 0;
    int exp_slot = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tslot_arbiter #(.LINE_SLOTS(L), .NUM_FIX(NF), .FIX_STRIDE(FS)) dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .fix_req(fix_req),
        .disp_req(disp_req), .cop_req(cop_req), .cpu_req(cpu_req),
        .cpu_shared(cpu_shared), .blt_req(blt_req), .blt_yield(blt_yield),
        .hblank(hblank), .vblank(vblank), .planes(planes),
        .gnt(gnt), .cpu_wait(cpu_wait), .slot_idx(slot_idx));

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s slot=%0d actual=0x%0h expected=0x%0h", tag, exp_slot, got, exp);
        end
    endtask

    // Compare every output of the current slot to the arithmetic model.
    task automatic check_slot();
        int p, n, own;
        bit claim, cpu_ok, blank;
        logic [NG-1:0] eg;
        string tag;
        p = exp_slot % 8;
        n = (planes > 4) ? 4 : int'(planes);
        own = -1;
        if ((exp_slot % 2) == 1 && ((exp_slot / 2) % FS) < NF) own = (exp_slot / 2) % FS;
        if (p == 1 || p == 5)      claim = (n >= 1);
        else if (p == 3 || p == 7) claim = (n >= 2);
        else if (p == 0 || p == 4) claim = (n >= 3);
        else                       claim = (n >= 4);
        blank  = hblank || vblank;
        cpu_ok = ((exp_slot % 2) == 0) && cpu_req && cpu_shared;
        eg = '0;
        tag = "R3";
        if (own >= 0 && fix_req[own]) begin
            eg[own] = 1'b1; tag = "R4";
        end else if (claim && disp_req && !blank) begin
            eg[BD] = 1'b1; tag = "R6";
        end else if (cop_req) begin
            eg[BC] = 1'b1; tag = "R8";
        end else if (blt_yield && cpu_ok) begin
            eg[BP] = 1'b1; tag = "R9";
        end else if (blt_req) begin
            eg[BB] = 1'b1; tag = blt_yield ? "R10" : "R9";
        end else if (cpu_ok) begin
            eg[BP] = 1'b1; tag = "R5";
        end else if (claim && disp_req && blank) begin
            tag = "R7";
        end
        chk("R1 slot", int'(slot_idx), exp_slot);
        chk(tag, int'(gnt), int'(eg));
        if (cpu_req && !cpu_shared) chk("R11 wait", int'(cpu_wait), 0);
        else                        chk("R12 wait", int'(cpu_wait), int'(cpu_ok && !eg[BP]));
    endtask

    task automatic advance();
        @(posedge clk);
        if (line_start)         exp_slot = 0;
        else if (exp_slot == L - 1) exp_slot = 0;
        else                    exp_slot = exp_slot + 1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        r = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_slot = 0;
        #1;
        // R1 / R3: reset state with idle requests.
        chk("R1 reset slot", int'(slot_idx), 0);
        chk("R3 reset gnt", int'(gnt), 0);
        advance();

        // R4 / R5 / R1: every fixed channel and the processor busy for two full lines.
        fix_req = '1; cpu_req = 1'b1; cpu_shared = 1'b1; blt_yield = 1'b1;
        for (int i = 0; i < 2 * L; i++) begin
            #1; check_slot(); advance();
        end

        // R2: restart in mid-line.
        line_start = 1'b1; #1; check_slot(); advance();
        line_start = 1'b0; #1; chk("R2 restart", int'(slot_idx), 0); advance();

        // R6 / R7: each plane count, active video and blanking, display only.
        fix_req = '0; cpu_req = 1'b0; blt_yield = 1'b0; disp_req = 1'b1;
        for (int pl = 0; pl < 6; pl++) begin
            for (int b = 0; b < 2; b++) begin
                planes = 3'(pl); hblank = (b == 1);
                for (int i = 0; i < 8; i++) begin
                    #1; check_slot(); advance();
                end
            end
        end
        hblank = 1'b0;

        // R9 / R10 / R11 / R12: pseudo-random sweep over all inputs.
        for (int c = 0; c < 20000; c++) begin
            r = r * 32'd1664525 + 32'd1013904223;
            fix_req    = r[3:0] & {4{r[21]}};
            disp_req   = r[4];
            cop_req    = r[5] & r[6];
            cpu_req    = r[7];
            cpu_shared = r[8] | r[9];
            blt_req    = r[10];
            blt_yield  = r[11];
            hblank     = r[12] & r[13];
            vblank     = r[14] & r[15] & r[16];
            line_start = (r[20:17] == 4'd0);
            planes     = 3'((r >> 24) % 6);
            #1; check_slot(); advance();
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule